// File: doc/BRIEF.md
# Routed Four-Accumulator Execute Stage

This block is the execute stage of a 16-bit accumulator CPU. It holds four 16-bit accumulators (A, B, C, D), one carry flag that all four share, and negative, zero and overflow flags. On each clock edge where `valid_i` is high it takes one instruction word and one operand. It then applies a logical operation (OR, AND, XOR), an add-with-carry or a subtract-with-carry to an accumulator and the operand. It can also copy one accumulator into another, or clear or set the carry.

A routing field in the instruction picks a source accumulator and a separate destination accumulator. The result of the operation can therefore go to a different accumulator than the one it read. The source keeps its value. Fetch, addressing modes and memory all sit upstream: this block only sees the instruction word and the operand value that has already been resolved.

Top module: `maccu_exec`

## Requirements
- R1: After reset, all four accumulators are 0x0000 and carry, negative, zero and overflow are all 0.
- R2: An instruction acts only if bits [15:14] are 00. An arithmetic/logic instruction has low-byte bits [1:0] = 01, and bits [7:5] select the operation: 000 OR, 001 AND, 010 XOR, 011 add with carry, 111 subtract with carry. Any other low byte that R9 and R10 do not define changes nothing, for example 0xA9.
- R3: When routing field bits [13:10] is 0 or one of the reserved codes 13 to 15, the operation reads and writes the accumulator given by bits [9:8], encoded 00=A, 01=B, 10=C, 11=D.
- R4: Routing codes 1 to 12 pick (source, destination) as follows: 1 (A,B), 2 (A,C), 3 (A,D), 4 (B,A), 5 (B,C), 6 (B,D), 7 (C,A), 8 (C,B), 9 (C,D), 10 (D,A), 11 (D,B), 12 (D,C). The operand is combined with the source, and the result is written to the destination.
- R5: Add with carry writes source + operand + carry. The carry becomes the adder's carry-out. Overflow is set when both addends have the same sign and the result's sign differs from it.
- R6: Subtract with carry writes source + ~operand + carry. Carry and overflow follow the rule of R5, with the inverted operand as the second addend. The same single carry is used whatever the accumulators are.
- R7: OR, AND and XOR update negative and zero but leave carry and overflow unchanged.
- R8: On every accumulator write, negative becomes bit 15 of the written value, and zero is set exactly when that value is 0x0000.
- R9: A transfer has low byte 10ss_1011 (0x8B, 0x9B, 0xAB, 0xBB). Bits [5:4] give the source and bits [9:8] the destination. It copies the value and updates negative and zero only. When source equals destination, nothing changes.
- R10: Low byte 0x18 clears the carry and 0x38 sets it, whatever bits [13:8] hold. No other state changes.
- R11: Only the destination accumulator and the flags change. A source that differs from the destination keeps its value. With `valid_i` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute the presented instruction on this edge |
| instr_i | input | 16 | Instruction word |
| operand_i | input | 16 | Resolved operand value |
| acc_o | output | 64 | Accumulators packed {D, C, B, A}, A in bits [15:0] |
| carry_o | output | 1 | Shared carry flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The hardest case to reach from the ports is a proof that each of the twelve routing codes reads exactly the source it claims and writes exactly the destination it claims. That proof needs all four accumulators to hold distinct values first, and there is no load port. The bench therefore loads each accumulator by clearing it with an in-place AND of zero and then ORing in a distinct constant. It clears the carry, runs one routed add, and checks all four accumulators, so a wrong source or a stray write shows up at once. This is repeated for every routing code. Shared-carry effects are reached by chaining routed adds and subtracts, so that one accumulator pair's carry feeds an operation on another pair.

// File: rtl/maccu_pkg.sv
package maccu_pkg;
  localparam int unsigned NACC = 4;
  localparam int unsigned IW   = $clog2(NACC);

  typedef enum logic [2:0] {
    OP_OR, OP_AND, OP_XOR, OP_ADC, OP_SBC, OP_MOV
  } alu_op_e;

  typedef struct packed {
    logic          wr;     // writes dst and N/Z
    logic          arith;  // also writes C/V
    logic          clc;
    logic          sec;
    alu_op_e       op;
    logic [IW-1:0] src;
    logic [IW-1:0] dst;
  } uop_t;
endpackage

// File: rtl/maccu_decode.sv
module maccu_decode
  import maccu_pkg::*;
(
  input  logic [15:0] instr_i,
  output uop_t        uop_o
);
  logic [7:0]    lo;
  logic [3:0]    code;
  logic [IW-1:0] sel;
  logic          legal;
  logic          is_alu, is_xfer;
  logic [3:0]    k;
  logic [IW-1:0] rsrc, rdst, j;

  assign lo    = instr_i[7:0];
  assign code  = instr_i[13:10];
  assign sel   = instr_i[9:8];
  assign legal = (instr_i[15:14] == 2'b00);

  assign is_alu  = legal && (lo[1:0] == 2'b01) && (!lo[7] || lo[7:5] == 3'b111);
  assign is_xfer = legal && (lo[7:6] == 2'b10) && (lo[3:0] == 4'b1011);

  // routing: codes 1..12 enumerate ordered pairs of distinct accumulators
  always_comb begin
    k = code - 4'd1;
    j = 2'(k % 4'd3);
    if (code == 4'd0 || code > 4'd12) begin
      rsrc = sel;
      rdst = sel;
    end else begin
      rsrc = 2'(k / 4'd3);
      rdst = (j >= rsrc) ? j + 2'd1 : j;
    end
  end

  always_comb begin
    uop_o       = '0;
    uop_o.op    = OP_OR;
    uop_o.clc   = legal && (lo == 8'h18);
    uop_o.sec   = legal && (lo == 8'h38);
    if (is_alu) begin
      uop_o.wr  = 1'b1;
      uop_o.src = rsrc;
      uop_o.dst = rdst;
      unique case (lo[7:5])
        3'b000:  uop_o.op = OP_OR;
        3'b001:  uop_o.op = OP_AND;
        3'b010:  uop_o.op = OP_XOR;
        3'b011:  uop_o.op = OP_ADC;
        default: uop_o.op = OP_SBC;
      endcase
      uop_o.arith = (lo[7:5] == 3'b011) || (lo[7:5] == 3'b111);
    end else if (is_xfer) begin
      uop_o.op  = OP_MOV;
      uop_o.src = lo[5:4];
      uop_o.dst = sel;
      uop_o.wr  = (lo[5:4] != sel);
    end
  end
endmodule

// File: rtl/maccu_alu.sv
module maccu_alu
  import maccu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          ovf_o
);
  logic [DW-1:0] bx;
  logic [DW:0]   sum;

  assign bx  = (op_i == OP_SBC) ? ~b_i : b_i;
  assign sum = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cin_i};

  always_comb begin
    cout_o = sum[DW];
    ovf_o  = (a_i[DW-1] == bx[DW-1]) && (sum[DW-1] != a_i[DW-1]);
    unique case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_MOV:  res_o = a_i;
      default: res_o = sum[DW-1:0];
    endcase
  end
endmodule

// File: rtl/maccu_accs.sv
module maccu_accs
  import maccu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NACC*DW-1:0] acc_o
);
  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && waddr_i == IW'(i))   q <= wdata_i;
    end
    assign acc_o[i*DW +: DW] = q;
  end
endmodule

// File: rtl/maccu_exec.sv
module maccu_exec
  import maccu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [15:0]        instr_i,
  input  logic [DW-1:0]      operand_i,
  output logic [NACC*DW-1:0] acc_o,
  output logic               carry_o,
  output logic               neg_o,
  output logic               zero_o,
  output logic               ovf_o
);
  uop_t          uop;
  logic [DW-1:0] acc_w [NACC];
  logic [DW-1:0] res;
  logic          cout, vout, we;
  logic          carry_q, neg_q, zero_q, ovf_q;

  maccu_decode u_dec (.instr_i(instr_i), .uop_o(uop));

  for (genvar i = 0; i < NACC; i++) begin : g_unpack
    assign acc_w[i] = acc_o[i*DW +: DW];
  end

  maccu_alu #(.DW(DW)) u_alu (
    .op_i(uop.op), .a_i(acc_w[uop.src]), .b_i(operand_i), .cin_i(carry_q),
    .res_o(res), .cout_o(cout), .ovf_o(vout)
  );

  assign we = valid_i && uop.wr;

  maccu_accs #(.DW(DW)) u_accs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .waddr_i(uop.dst),
    .wdata_i(res), .acc_o(acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (valid_i) begin
      if (uop.wr) begin
        neg_q  <= res[DW-1];
        zero_q <= (res == '0);
        if (uop.arith) begin
          carry_q <= cout;
          ovf_q   <= vout;
        end
      end
      if (uop.clc) carry_q <= 1'b0;
      if (uop.sec) carry_q <= 1'b1;
    end
  end

  assign carry_o = carry_q;
  assign neg_o   = neg_q;
  assign zero_o  = zero_q;
  assign ovf_o   = ovf_q;

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o) && $stable({carry_q, neg_q, zero_q, ovf_q}));

  a_r10_clear_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[15:14] == 2'b00 && instr_i[7:0] == 8'h18 |=> !carry_q);

  a_r10_set_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[15:14] == 2'b00 && instr_i[7:0] == 8'h38 |=> carry_q);

  a_r7_logic_keeps_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && uop.wr && !uop.arith |=> $stable({carry_q, ovf_q}));

  a_r8_zero_tracks_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> zero_q == (acc_w[$past(uop.dst)] == '0));

  a_r8_neg_tracks_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> neg_q == acc_w[$past(uop.dst)][DW-1]);

  a_r11_src_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we && uop.src != uop.dst |=> acc_w[$past(uop.src)] == $past(acc_w[uop.src]));
endmodule

// File: tb/tb_maccu_exec.sv
module tb_maccu_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] operand_i = '0;
  logic [63:0] acc_o;
  logic        carry_o, neg_o, zero_o, ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maccu_exec dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .operand_i(operand_i), .acc_o(acc_o), .carry_o(carry_o), .neg_o(neg_o),
    .zero_o(zero_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] opd;
    logic [63:0] acc;  // {D,C,B,A}
    logic [3:0]  flg;  // {C,N,Z,V}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    {16'h0038, 16'h0000, 64'h0000_0000_0000_0000, 4'b1000}, // R10 set carry
    {16'h0069, 16'h0010, 64'h0000_0000_0000_0011, 4'b0000}, // R5 add in place A
    {16'h0469, 16'h7FF0, 64'h0000_0000_8001_0011, 4'b0101}, // R4 A->B add, overflow
    {16'h0129, 16'h00FF, 64'h0000_0000_0001_0011, 4'b0001}, // R7 AND keeps C,V
    {16'h3F38, 16'h0000, 64'h0000_0000_0001_0011, 4'b1001}, // R10 set, fields ignored
    {16'h1CE9, 16'h0001, 64'h0000_0000_0001_FFFF, 4'b0100}, // R6 C->A subtract
    {16'h3049, 16'hFFFF, 64'h0000_FFFF_0001_FFFF, 4'b0100}, // R4 D->C XOR
    {16'h038B, 16'h0000, 64'hFFFF_FFFF_0001_FFFF, 4'b0100}, // R9 transfer A->D
    {16'h3B69, 16'h0001, 64'h0000_FFFF_0001_FFFF, 4'b1010}, // R3 reserved code 14 on D
    {16'h0009, 16'h0000, 64'h0000_FFFF_0001_FFFF, 4'b1100}, // R8 OR sets N
    {16'h019B, 16'h0000, 64'h0000_FFFF_0001_FFFF, 4'b1100}, // R9 B->B no-op
    {16'h00A9, 16'h1234, 64'h0000_FFFF_0001_FFFF, 4'b1100}, // R2 undefined low byte
    {16'h4069, 16'h1234, 64'h0000_FFFF_0001_FFFF, 4'b1100}, // R2 bits[15:14] nonzero
    {16'h01E9, 16'h0001, 64'h0000_FFFF_0000_FFFF, 4'b1010}, // R6 subtract to zero on B
    {16'h1069, 16'h8000, 64'h0000_FFFF_0000_8001, 4'b0100}  // R4 B->A, shared carry
  };
  localparam string TAG [NV] = '{"R10", "R5", "R4", "R7", "R10", "R6", "R4", "R9",
                                 "R3", "R8", "R9", "R2", "R2", "R6", "R4"};

  // stated routing pairs for codes 1..12
  localparam int RSRC [12] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 3, 3, 3};
  localparam int RDST [12] = '{1, 2, 3, 0, 2, 3, 0, 1, 3, 0, 1, 2};

  task automatic chk(input string tag, input logic [63:0] ea, input logic [3:0] ef);
    checks++;
    if (acc_o !== ea || {carry_o, neg_o, zero_o, ovf_o} !== ef) begin
      errors++;
      $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
               tag, acc_o, {carry_o, neg_o, zero_o, ovf_o}, ea, ef);
    end
  endtask

  task automatic exec(input logic [15:0] ins, input logic [15:0] opd);
    @(negedge clk);
    valid_i   = 1'b1;
    instr_i   = ins;
    operand_i = opd;
    @(negedge clk);
    valid_i   = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_acc;
    logic [15:0] v [4];
    repeat (2) @(negedge clk);
    chk("R1 reset", 64'h0, 4'b0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      exec(VEC[i].ins, VEC[i].opd);
      chk($sformatf("%s row %0d", TAG[i], i), VEC[i].acc, VEC[i].flg);
    end

    // R4 sweep of all routing codes with distinct accumulator contents
    for (int c = 1; c <= 12; c++) begin
      for (int a = 0; a < 4; a++) begin
        v[a] = 16'h1000 * 16'(a + 1) + 16'(c);
        exec({6'b0, 2'(a), 8'h29}, 16'h0000);
        exec({6'b0, 2'(a), 8'h09}, v[a]);
      end
      exec(16'h0018, 16'h0000);
      exec({2'b00, 4'(c), 2'b00, 8'h69}, 16'h0005);
      v[RDST[c-1]] = v[RSRC[c-1]] + 16'h0005;
      exp_acc = {v[3], v[2], v[1], v[0]};
      chk($sformatf("R4 route code %0d", c), exp_acc, 4'b0000);
    end

    // R11 nothing changes without valid
    @(negedge clk);
    instr_i = 16'h0038; operand_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R11 valid low", exp_acc, 4'b0000);

    // R10 clear after set, with routing fields populated
    exec(16'h0038, 16'h0000);
    exec(16'h3718, 16'h0000);
    chk("R10 clear carry", exp_acc, 4'b0000);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", 64'h0, 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule